// File: doc/BRIEF.md
# Configurable Bus-Width Matching Port

This block sits between a narrow external data port and a 36-bit memory word organised as four 9-bit lanes. Two static configuration inputs choose how wide the external port is: the full 36 bits, an 18-bit half-word, or a 9-bit single lane. A fourth setting keeps the port active but floats every data pin and blocks all data transfer. For the narrow widths, two lane-address inputs act as extra low-order address bits. They steer the selected half or lane of the word onto the lowest pins.

On a write, the block produces one write enable per lane and places the narrow input data into the chosen lane positions. Lanes that are not enabled keep their contents in the array. On a read, the chosen part of the array word is moved down to the low pins and registered. The per-bit output enables turn on, one cycle after the read strobe, only for the pins the current width uses. The configuration is registered, so a change takes effect from the clock cycle after it is applied.

Top module: `bus_width_port`

## Requirements
- R1: In full mode (cfg_match=0, cfg_size=0), a write asserts all four lane enables and arr_wdata equals pin_in. word_sel and lane_sel have no effect.
- R2: In half mode (cfg_match=1, cfg_size=0), a write enables lanes 0 and 1 when word_sel=0 and lanes 2 and 3 when word_sel=1. Each enabled lane carries pin_in[17:0] placed at the matching position, and lane_sel has no effect.
- R3: In lane mode (cfg_match=1, cfg_size=1), a write enables only the lane whose index is {word_sel,lane_sel}, and that lane carries pin_in[8:0]. Lane 0 is bits 0-8, lane 1 is bits 9-17, lane 2 is bits 18-26 and lane 3 is bits 27-35.
- R4: In full mode, one cycle after a read strobe, pin_out equals the array word and all 36 bits of pin_oe are 1.
- R5: In half mode, one cycle after a read strobe, pin_out[17:0] holds the upper half of the word (word_sel=1) or the lower half (word_sel=0), and pin_oe is 1 only on bits 0-17.
- R6: In lane mode, one cycle after a read strobe, pin_out[8:0] holds the lane with index {word_sel,lane_sel}, and pin_oe is 1 only on bits 0-8.
- R7: In disabled mode (cfg_match=0, cfg_size=1), no lane enable, no array read strobe and no pin_oe bit is ever asserted.
- R8: A change on cfg_match/cfg_size is used from the clock edge that follows it. In the cycle where the inputs change, the previous mode still decides the lane enables.
- R9: After reset, and in any cycle that does not follow a read strobe, pin_oe is all zero. The mode after reset is full mode.
- R10: Without wr_req, no lane enable is asserted in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_match | input | 1 | Width configuration, high bit |
| cfg_size | input | 1 | Width configuration, low bit |
| word_sel | input | 1 | Half select, also high bit of the lane index |
| lane_sel | input | 1 | Low bit of the lane index |
| wr_req | input | 1 | Write strobe |
| rd_req | input | 1 | Read strobe |
| pin_in | input | 36 | Data arriving from the external pins |
| pin_out | output | 36 | Registered read data to the pins |
| pin_oe | output | 36 | Per-bit output enable for the pins |
| arr_we | output | 4 | Per-lane write enable to the array |
| arr_wdata | output | 36 | Write data to the array |
| arr_re | output | 1 | Read strobe to the array |
| arr_rdata | input | 36 | Word returned by the array in the same cycle |

## Verification
The assertions assume that the array returns arr_rdata in the same cycle as the read strobe. They also assume that word_sel, lane_sel and the strobes are stable around each clock edge, and that the mode inputs change only between transfers. The bench drives every input on the falling edge and holds the mode for at least one rising edge before it issues a transfer. The only exception is one deliberate case, in which the mode and a write change together to observe the one-cycle configuration latency.

// File: rtl/bus_width_port.sv
module bus_width_port #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_match,
  input  logic                     cfg_size,
  input  logic                     word_sel,
  input  logic                     lane_sel,
  input  logic                     wr_req,
  input  logic                     rd_req,
  input  logic [LANE_W*LANES-1:0]  pin_in,
  output logic [LANE_W*LANES-1:0]  pin_out,
  output logic [LANE_W*LANES-1:0]  pin_oe,
  output logic [LANES-1:0]         arr_we,
  output logic [LANE_W*LANES-1:0]  arr_wdata,
  output logic                     arr_re,
  input  logic [LANE_W*LANES-1:0]  arr_rdata
);
  localparam int DW   = LANE_W * LANES;
  localparam int HW   = DW / 2;
  localparam int HL   = LANES / 2;
  localparam int IDXW = $clog2(LANES);

  localparam logic [1:0] M_FULL = 2'b00;
  localparam logic [1:0] M_OFF  = 2'b01;
  localparam logic [1:0] M_HALF = 2'b10;
  localparam logic [1:0] M_LANE = 2'b11;

  logic [1:0]      mode_q;
  logic [IDXW-1:0] lane_idx;
  logic [LANES-1:0] lane_mask;
  logic [DW-1:0]   pin_mask;
  logic [DW-1:0]   rd_steer;
  logic [DW-1:0]   rd_q;
  logic [DW-1:0]   oe_q;

  assign lane_idx = {word_sel, lane_sel};

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= M_FULL;
    else        mode_q <= {cfg_match, cfg_size};
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      unique case (mode_q)
        M_FULL: lane_mask[i] = 1'b1;
        M_HALF: lane_mask[i] = ((i >= HL) == word_sel);
        M_LANE: lane_mask[i] = (IDXW'(i) == lane_idx);
        default: lane_mask[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    unique case (mode_q)
      M_FULL:  pin_mask = '1;
      M_HALF:  pin_mask = {{(DW-HW){1'b0}}, {HW{1'b1}}};
      M_LANE:  pin_mask = {{(DW-LANE_W){1'b0}}, {LANE_W{1'b1}}};
      default: pin_mask = '0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      unique case (mode_q)
        M_HALF:  arr_wdata[i*LANE_W +: LANE_W] = pin_in[(i % HL)*LANE_W +: LANE_W];
        M_LANE:  arr_wdata[i*LANE_W +: LANE_W] = pin_in[LANE_W-1:0];
        default: arr_wdata[i*LANE_W +: LANE_W] = pin_in[i*LANE_W +: LANE_W];
      endcase
    end
  end

  always_comb begin
    rd_steer = '0;
    unique case (mode_q)
      M_FULL: rd_steer = arr_rdata;
      M_HALF: rd_steer[HW-1:0] = word_sel ? arr_rdata[DW-1:HW] : arr_rdata[HW-1:0];
      M_LANE: rd_steer[LANE_W-1:0] = arr_rdata[lane_idx*LANE_W +: LANE_W];
      default: rd_steer = '0;
    endcase
  end

  assign arr_we = wr_req ? lane_mask : '0;
  assign arr_re = rd_req && (mode_q != M_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0;
      oe_q <= '0;
    end else begin
      if (arr_re) rd_q <= rd_steer;
      oe_q <= arr_re ? pin_mask : '0;
    end
  end

  assign pin_out = rd_q;
  assign pin_oe  = oe_q;

  p_full_all_lanes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FULL && wr_req) |-> (&arr_we));

  p_half_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HALF && wr_req) |-> ($countones(arr_we) == 2));

  p_lane_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_LANE) |-> ($countones(arr_we) <= 1));

  p_half_upper_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && mode_q == M_HALF) |=> (pin_oe[DW-1:HW] == '0));

  p_lane_upper_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && mode_q == M_LANE) |=> (pin_oe[DW-1:LANE_W] == '0));

  p_off_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF) |-> (arr_we == '0 && !arr_re));

  p_off_no_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF) |=> (pin_oe == '0));

  p_oe_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (pin_oe == '0));

  p_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |-> (arr_we == '0));
endmodule

// File: tb/bus_width_port_tb.sv
module bus_width_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_match = 1'b0, cfg_size = 1'b0, word_sel = 1'b0, lane_sel = 1'b0;
  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [35:0] pin_in = '0, arr_rdata = '0;
  logic [35:0] pin_out, pin_oe, arr_wdata;
  logic [3:0]  arr_we;
  logic        arr_re;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_width_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_match(cfg_match), .cfg_size(cfg_size),
    .word_sel(word_sel), .lane_sel(lane_sel), .wr_req(wr_req), .rd_req(rd_req),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .arr_we(arr_we),
    .arr_wdata(arr_wdata), .arr_re(arr_re), .arr_rdata(arr_rdata)
  );

  task automatic chk(input string req, input bit ok, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_we(input int m, input int ws, input int bs);
    case (m)
      0: return 4'b1111;
      2: return ws ? 4'b1100 : 4'b0011;
      3: return 4'(1 << (ws*2 + bs));
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [35:0] exp_oe(input int m);
    case (m)
      0: return {36{1'b1}};
      2: return 36'h3FFFF;
      3: return 36'h1FF;
      default: return 36'h0;
    endcase
  endfunction

  function automatic logic [35:0] exp_rd(input int m, input int ws, input int bs, input logic [35:0] w);
    case (m)
      0: return w;
      2: return (w >> (ws*18)) & 36'h3FFFF;
      3: return (w >> ((ws*2 + bs)*9)) & 36'h1FF;
      default: return 36'h0;
    endcase
  endfunction

  function automatic logic [35:0] exp_wd(input int m, input logic [35:0] d);
    logic [35:0] r;
    for (int i = 0; i < 4; i++) begin
      if (m == 0)      r[i*9 +: 9] = d[i*9 +: 9];
      else if (m == 2) r[i*9 +: 9] = d[(i % 2)*9 +: 9];
      else             r[i*9 +: 9] = d[8:0];
    end
    return r;
  endfunction

  function automatic logic [35:0] lane_bits(input logic [3:0] we);
    logic [35:0] r;
    for (int i = 0; i < 4; i++) r[i*9 +: 9] = {9{we[i]}};
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R9 reset oe", pin_oe == '0, pin_oe, '0);
    wr_req = 1'b1; word_sel = 1'b1; lane_sel = 1'b0; pin_in = 36'h9_8765_4321;
    #1;
    chk("R9 reset mode is full", arr_we == 4'b1111, 36'(arr_we), 36'hF);
    wr_req = 1'b0;

    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      {cfg_match, cfg_size} = 2'(m);
      @(posedge clk);
      for (int ws = 0; ws < 2; ws++)
        for (int bs = 0; bs < 2; bs++)
          for (int k = 0; k < 3; k++) begin
            logic [35:0] d, w, mk;
            d = 36'h1_2345_6789 ^ (36'(k) * 36'h3_C3C3_C3C5);
            w = 36'hA_BCDE_F012 + (36'(k*7 + ws*3 + bs) * 36'h1_1111_1111);
            tag = (m == 0) ? "R1" : (m == 2) ? "R2" : (m == 3) ? "R3" : "R7";
            @(negedge clk);
            word_sel = ws[0]; lane_sel = bs[0];
            pin_in = d; arr_rdata = w; wr_req = 1'b1; rd_req = 1'b1;
            #2;
            chk({tag, " lane enables"}, arr_we == exp_we(m, ws, bs), 36'(arr_we), 36'(exp_we(m, ws, bs)));
            mk = lane_bits(exp_we(m, ws, bs));
            chk({tag, " write data"}, (arr_wdata & mk) == (exp_wd(m, d) & mk),
                arr_wdata & mk, exp_wd(m, d) & mk);
            if (m == 1) chk("R7 no array read", arr_re == 1'b0, 36'(arr_re), 36'h0);
            @(negedge clk);
            wr_req = 1'b0; rd_req = 1'b0;
            tag = (m == 0) ? "R4" : (m == 2) ? "R5" : (m == 3) ? "R6" : "R7";
            #2;
            chk({tag, " output enable"}, pin_oe == exp_oe(m), pin_oe, exp_oe(m));
            chk({tag, " read data"}, (pin_out & exp_oe(m)) == exp_rd(m, ws, bs, w),
                pin_out & exp_oe(m), exp_rd(m, ws, bs, w));
            #1;
            chk("R10 idle no enables", arr_we == '0, 36'(arr_we), 36'h0);
            @(negedge clk);
            #2;
            chk("R9 oe drops without read", pin_oe == '0, pin_oe, '0);
          end
    end

    @(negedge clk);
    {cfg_match, cfg_size} = 2'b00;
    @(negedge clk);
    {cfg_match, cfg_size} = 2'b11;
    word_sel = 1'b1; lane_sel = 1'b1; wr_req = 1'b1;
    #2;
    chk("R8 old mode this cycle", arr_we == 4'b1111, 36'(arr_we), 36'hF);
    @(negedge clk);
    #2;
    chk("R8 new mode next cycle", arr_we == 4'b1000, 36'(arr_we), 36'h8);
    wr_req = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule